// File: doc/BRIEF.md
# Ping-pong byte capture writer

This block drains 8-bit bytes from a peripheral receive FIFO into memory, filling two buffers in turn. Each byte is taken from the same fixed source, the FIFO's data output. Each byte lands at the next byte address of the active buffer. Two descriptors, primary and alternate, each hold a buffer base address, a count field and a mode field. The count field is the number of items minus one. While one buffer fills, software may process the other.

When the active buffer takes its last item, the block does three things at once. It stops that descriptor, so its mode reads back as 0. It sets that descriptor's done bit, which raises the interrupt. It moves to the other descriptor, so the next byte goes to the other buffer with no lost cycle. The interrupt handler finds the finished buffer from the done bits or from the mode fields. It then rewrites that descriptor to arm it again.

After every burst of accepted bytes, the block lowers its ready output for one cycle. This gives other FIFO users a chance at arbitration before the block requests again. If no descriptor is armed, an arriving byte is still accepted, so the FIFO never stalls. That byte is discarded and a sticky overrun flag is set.

Top module: `pingpong_byte_writer`

## Requirements
- R1: After reset, every register reads 0, `in_ready` is 1, and `irq` and `mem_we` are 0.
- R2: An accepted byte is written in the same cycle to `mem_addr` = active base + item index, with `mem_wdata` equal to the byte. The index starts at 0 and rises by one for each item.
- R3: A descriptor takes count+1 items. After its last item, its mode field (control bits [2:0]) reads 0 and its done bit is set. Status bit 0 is primary done and bit 1 is alternate done.
- R4: After a buffer completes, the next accepted byte goes to index 0 of the other descriptor, provided that descriptor is armed. There is no idle cycle between the two.
- R5: After every 8 accepted bytes, `in_ready` is low for exactly the next cycle and then returns high.
- R6: A descriptor is armed only when its mode field is 3. Any other mode value is treated as stopped and reads back unchanged.
- R7: A byte that arrives while neither descriptor is armed is accepted and not written. It sets the overrun flag (status bit 2), which stays set until it is cleared.
- R8: Status bits are cleared by writing 1 to them, and each bit clears independently of the others. `irq` is high while either done bit is set.
- R9: Writing a stopped descriptor's control register with mode 3 arms it again with the new count. Writing its base register sets a new base.

Register offsets (`reg_addr`): 0 primary base, 1 primary control, 2 alternate base, 3 alternate control, 4 status. A control word holds mode in bits [2:0] and count in bits [CNT_W+3:4].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| in_valid | input | 1 | FIFO has a byte |
| in_data | input | 8 | FIFO byte |
| in_ready | output | 1 | Block takes the byte this cycle |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_wdata | output | 8 | Memory write data |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational |
| irq | output | 1 | Buffer-complete interrupt |

## Verification
The memory write is combinational with the handshake, so its address and data are due in the same cycle the byte is offered. Mode fields, done bits, overrun and `irq` change on the clock edge that accepts the byte, and are due one cycle later. The ready gap is due in the cycle right after the eighth accepted byte. The bench drives inputs on the falling edge, samples 1 ns later, and reads registers only in cycles after the edge that updated them.

// File: rtl/pingpong_byte_writer.sv
module pingpong_byte_writer #(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 10,
  parameter int BURST  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [7:0]        in_data,
  output logic              in_ready,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  input  logic              reg_we,
  input  logic [2:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              irq
);

  localparam int BC_W = (BURST > 1) ? $clog2(BURST) : 1;
  localparam logic [2:0] MODE_PP   = 3'd3;
  localparam logic [2:0] MODE_STOP = 3'd0;

  logic [ADDR_W-1:0] base [2];
  logic [CNT_W-1:0]  cnt  [2];
  logic [2:0]        mode [2];
  logic              sel;
  logic [CNT_W-1:0]  idx;
  logic [1:0]        done;
  logic              ovr;
  logic              pause;
  logic [BC_W-1:0]   beat;

  logic              eff;
  logic              any_armed;
  logic [CNT_W-1:0]  idx_use;
  logic              accept;
  logic              last;

  wire armed0 = (mode[0] == MODE_PP);
  wire armed1 = (mode[1] == MODE_PP);

  always_comb begin
    if (sel ? armed1 : armed0) eff = sel;
    else                       eff = ~sel;
  end

  assign any_armed = armed0 | armed1;
  assign idx_use   = (eff == sel) ? idx : '0;
  assign last      = (idx_use == cnt[eff]);
  assign in_ready  = ~pause;
  assign accept    = in_valid & in_ready;
  assign mem_we    = accept & any_armed;
  assign mem_addr  = base[eff] + ADDR_W'(idx_use);
  assign mem_wdata = in_data;
  assign irq       = |done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pause <= 1'b0;
      beat  <= '0;
    end else begin
      pause <= 1'b0;
      if (accept) begin
        if (beat == BC_W'(BURST - 1)) begin
          beat  <= '0;
          pause <= 1'b1;
        end else begin
          beat <= beat + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base[0] <= '0;
      base[1] <= '0;
      cnt[0]  <= '0;
      cnt[1]  <= '0;
      mode[0] <= MODE_STOP;
      mode[1] <= MODE_STOP;
      sel     <= 1'b0;
      idx     <= '0;
      done    <= '0;
      ovr     <= 1'b0;
    end else begin
      if (reg_we && reg_addr == 3'd4) begin
        done <= done & ~reg_wdata[1:0];
        if (reg_wdata[2]) ovr <= 1'b0;
      end
      if (accept) begin
        if (!any_armed) begin
          ovr <= 1'b1;
        end else if (last) begin
          mode[eff] <= MODE_STOP;
          done[eff] <= 1'b1;
          sel       <= ~eff;
          idx       <= '0;
        end else begin
          sel <= eff;
          idx <= idx_use + 1'b1;
        end
      end
      if (reg_we) begin
        case (reg_addr)
          3'd0: base[0] <= reg_wdata[ADDR_W-1:0];
          3'd1: begin
            mode[0] <= reg_wdata[2:0];
            cnt[0]  <= reg_wdata[CNT_W+3:4];
          end
          3'd2: base[1] <= reg_wdata[ADDR_W-1:0];
          3'd3: begin
            mode[1] <= reg_wdata[2:0];
            cnt[1]  <= reg_wdata[CNT_W+3:4];
          end
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      3'd0: reg_rdata[ADDR_W-1:0] = base[0];
      3'd1: begin
        reg_rdata[2:0]        = mode[0];
        reg_rdata[CNT_W+3:4]  = cnt[0];
      end
      3'd2: reg_rdata[ADDR_W-1:0] = base[1];
      3'd3: begin
        reg_rdata[2:0]        = mode[1];
        reg_rdata[CNT_W+3:4]  = cnt[1];
      end
      3'd4: reg_rdata[2:0] = {ovr, done};
      default: ;
    endcase
  end

  p_gap_one_cycle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |=> in_ready);

  p_overrun_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr) |-> $past(accept && !mem_we));

  p_overrun_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr && !(reg_we && reg_addr == 3'd4 && reg_wdata[2])) |=> ovr);

  p_done_stops_pri_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(done[0]) && !$past(reg_we)) |-> (mode[0] == MODE_STOP));

  p_done_stops_alt_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(done[1]) && !$past(reg_we)) |-> (mode[1] == MODE_STOP));

  p_addr_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && !last && !reg_we) |=> (!mem_we || mem_addr == $past(mem_addr) + 1'b1));

endmodule

// File: tb/pingpong_byte_writer_test.sv
module pingpong_byte_writer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [7:0]  in_data = '0;
  logic        in_ready;
  logic        mem_we;
  logic [15:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq;

  always #5 clk = ~clk;

  pingpong_byte_writer uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  int n_run = 0, n_fail = 0;
  int mb[2], mc[2], mm[2];
  int msel = 0, midx = 0, acc = 0;
  bit b2b = 0;
  bit mdone[2];
  bit movr = 0;

  task automatic chk(bit ok, string tag, longint act, longint exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(int a, int d);
    @(negedge clk);
    in_valid = 1'b0; reg_we = 1'b1; reg_addr = 3'(a); reg_wdata = 32'(d);
    @(posedge clk); #1 reg_we = 1'b0;
    b2b = 0;
  endtask

  task automatic rd(int a, output logic [31:0] v);
    @(negedge clk);
    in_valid = 1'b0; reg_addr = 3'(a);
    #1 v = reg_rdata;
    b2b = 0;
  endtask

  task automatic arm(int i, int b, int c, int md);
    wr(i*2, b);
    wr(i*2+1, (c << 4) | md);
    mb[i] = b; mc[i] = c; mm[i] = md;
  endtask

  task automatic clr(int mask);
    wr(4, mask);
    if (mask[0]) mdone[0] = 0;
    if (mask[1]) mdone[1] = 0;
    if (mask[2]) movr = 0;
  endtask

  task automatic push(logic [7:0] d);
    int e, ix;
    @(negedge clk);
    in_valid = 1'b1; in_data = d;
    #1;
    if (b2b && acc % 8 == 0 && acc != 0) begin
      chk(!in_ready, "R5 ready low after burst", in_ready, 0);
      @(negedge clk); #1;
    end
    chk(in_ready, "R5 ready high", in_ready, 1);
    if (mm[msel] == 3) e = msel;
    else if (mm[1-msel] == 3) e = 1 - msel;
    else e = -1;
    if (e < 0) begin
      chk(!mem_we, "R7 no write when stopped", mem_we, 0);
      movr = 1;
    end else begin
      ix = (e == msel) ? midx : 0;
      if (ix == 0)
        chk(mem_we && mem_addr == 16'(mb[e] + ix), "R4 first item address",
            mem_addr, 16'(mb[e] + ix));
      else
        chk(mem_we && mem_addr == 16'(mb[e] + ix), "R2 item address",
            mem_addr, 16'(mb[e] + ix));
      chk(mem_wdata == d, "R2 write data", mem_wdata, d);
      if (ix == mc[e]) begin
        mm[e] = 0; mdone[e] = 1; msel = 1 - e; midx = 0;
      end else begin
        msel = e; midx = ix + 1;
      end
    end
    acc++;
    @(posedge clk); #1 in_valid = 1'b0;
    b2b = 1;
  endtask

  task automatic check_state(string tag);
    logic [31:0] v;
    rd(4, v);
    chk(v[2:0] == {movr, mdone[1], mdone[0]}, "R8 status bits", v[2:0],
        {movr, mdone[1], mdone[0]});
    chk(irq == (mdone[0] | mdone[1]), "R8 irq level", irq, mdone[0] | mdone[1]);
    rd(1, v);
    chk(v[2:0] == 3'(mm[0]), "R3 primary mode readback", v[2:0], mm[0]);
    rd(3, v);
    chk(v[2:0] == 3'(mm[1]), "R3 alternate mode readback", v[2:0], mm[1]);
  endtask

  initial begin
    #1_000_000;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] v;
    mdone[0] = 0; mdone[1] = 0;
    mm[0] = 0; mm[1] = 0; mb[0] = 0; mb[1] = 0; mc[0] = 0; mc[1] = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    for (int a = 0; a < 5; a++) begin
      rd(a, v);
      chk(v == 0, "R1 register reset value", v, 0);
    end
    chk(in_ready && !irq && !mem_we, "R1 output reset values",
        {in_ready, irq, mem_we}, 3'b100);

    for (int c0 = 0; c0 < 6; c0++) begin
      for (int c1 = 0; c1 < 6; c1++) begin
        arm(0, 'h100 + c0 * 16, c0, 3);
        arm(1, 'h800 + c1 * 32, c1, 3);
        for (int k = 0; k < c0 + c1 + 2; k++) push(8'(c0 * 37 + c1 * 11 + k));
        check_state("sweep");
        push(8'hA5);
        check_state("overrun");
        clr(1);
        check_state("clear primary only");
        clr(6);
        check_state("clear rest");
      end
    end

    arm(0, 'h2000, 5, 5);
    arm(1, 'h3000, 5, 0);
    rd(1, v);
    chk(v[2:0] == 3'd5, "R6 non-ping-pong mode kept", v[2:0], 5);
    push(8'h3C);
    check_state("R6 mode 5 is stopped");
    clr(7);

    arm(0, 'h4000, 63, 3);
    arm(1, 'h5000, 63, 3);
    for (int buf_n = 0; buf_n < 4; buf_n++) begin
      for (int k = 0; k < 64; k++) push(8'(buf_n * 64 + k));
      check_state("R9 stream");
      if (buf_n % 2 == 0) begin
        chk(mm[0] == 0 && mdone[0], "R9 primary stopped", mm[0], 0);
        clr(1);
        arm(0, 'h4000 + (buf_n + 2) * 64, 63, 3);
      end else begin
        clr(2);
        arm(1, 'h5000 + (buf_n + 2) * 64, 63, 3);
      end
      rd(buf_n % 2 == 0 ? 1 : 3, v);
      chk(v[2:0] == 3'd3, "R9 rearmed mode", v[2:0], 3);
    end
    check_state("final");

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule